// File: doc/BRIEF.md
# VGA Indexed Register Port

This block keeps the sequencer and graphics-controller register files of a standard VGA adapter. Each file is reached through a pair of I/O ports: writing the first port of the pair selects an entry, and writing the second port stores a byte into the selected entry. Port writes are one byte or 16 bits wide. A 16-bit write is split into two byte writes that are applied in order within one clock. When a byte is stored, the bits that the adapter does not implement are cleared, so those bits always read back as zero. The memory datapaths read every stored register from flat output buses.

The block also keeps a registered "standard mode" flag, which is true when sequencer entry 7 holds zero. It drives a three-state shadow-cache state machine. The states are IDLE_UNINIT (code 0), CACHE_ON (code 1) and CACHE_OFF (code 2). There are two transitions. ARM goes from IDLE_UNINIT to CACHE_ON on a rising edge of the standard-mode flag. DROP goes from CACHE_ON to CACHE_OFF when the disable request is high. No other transition exists, so CACHE_OFF is terminal until reset and a cache that has been disabled never comes back on.

All outputs are registered. The effect of a write that is presented on a rising clock edge is visible after that edge.

Top module: `vga_idx_port`

## Requirements
- R1: A byte write to port 0x3C4 loads the sequencer index. A byte write to 0x3C5 stores the data into the sequencer entry that the index selects. Entry i is visible on `seq_regs[8i+7:8i]` after the edge.
- R2: Ports 0x3CE and 0x3CF do the same for the graphics file. Entry i is visible on `gfx_regs[8i+7:8i]`.
- R3: Sequencer entries 0..7 keep only the bits in these masks: 0x03, 0x3D, 0x0F, 0x3F, 0x0E, 0x00, 0x00, 0xFF. All other bits are stored as zero.
- R4: Graphics entries 0..8 keep only the bits in these masks: 0x0F, 0x0F, 0x0F, 0x1F, 0x03, 0x7B, 0x0F, 0x0F, 0xFF.
- R5: A data write whose index is 8 or above (sequencer) or 9 or above (graphics) changes no entry. It raises `wr_unhandled` for one cycle after the edge.
- R6: A write to any port other than the four above changes no entry and raises `wr_unhandled`. Without a write, `wr_unhandled` is low.
- R7: A 16-bit write applies the low byte to `io_port` first and then the high byte to `io_port+1`. `wr_unhandled` is raised if either byte is unhandled.
- R8: `std_mode` is re-evaluated on every port write as (sequencer entry 7 == 0) after that write. It holds its value between writes.
- R9: ARM: in IDLE_UNINIT, a write that takes `std_mode` from 0 to 1 moves `cache_state` to CACHE_ON (1). Nothing else leaves IDLE_UNINIT.
- R10: DROP: in CACHE_ON, `cache_drop` moves the state to CACHE_OFF (2). `cache_drop` is ignored in IDLE_UNINIT. CACHE_OFF never changes, even on a new rise of `std_mode`.
- R11: After reset, all entries, both indices and `std_mode` are zero, `wr_unhandled` is low, and `cache_state` is IDLE_UNINIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Port write strobe |
| io_wide | input | 1 | 1 = 16-bit write, 0 = byte write |
| io_port | input | 16 | Port address of the low byte |
| io_data | input | 16 | Write data; the high byte is used only when wide |
| cache_drop | input | 1 | Request to disable the shadow cache |
| seq_regs | output | 64 | Sequencer entries 0..7, one byte each |
| gfx_regs | output | 72 | Graphics entries 0..8, one byte each |
| std_mode | output | 1 | Standard-mode flag |
| cache_state | output | 2 | Cache state: 0 IDLE_UNINIT, 1 CACHE_ON, 2 CACHE_OFF |
| wr_unhandled | output | 1 | Previous write was not handled |

## Verification
The masking is tested with all-ones data and with mixed patterns such as 0xAB and 0x5A. All-ones shows the mask itself, and a mixed pattern separates "keep" bits from "force" bits. Wide writes are tested with an index in the low byte and data in the high byte, which shows that the two bytes are applied low first. A wide write that starts on a data port shows that the high byte moves on to the neighbouring, unhandled port. The cache machine is driven along three sequences. In the first, the flag rises at the first write and the state arms. In the second, the flag starts false, a drop request arrives while the state is uninitialized and must be ignored, and then the flag rises. In the third, the flag rises again after a drop and the state must stay disabled.

// File: rtl/vga_idx_pkg.sv
package vga_idx_pkg;

    localparam logic [15:0] PORT_SEQ_IDX = 16'h03C4;
    localparam logic [15:0] PORT_SEQ_DAT = 16'h03C5;
    localparam logic [15:0] PORT_GFX_IDX = 16'h03CE;
    localparam logic [15:0] PORT_GFX_DAT = 16'h03CF;

    typedef enum logic [1:0] {
        IDLE_UNINIT = 2'd0,
        CACHE_ON    = 2'd1,
        CACHE_OFF   = 2'd2
    } cache_st_t;

    // implemented-bit masks, sequencer file
    function automatic logic [7:0] seq_keep(input logic [3:0] i);
        case (i)
            4'd0:    return 8'h03;
            4'd1:    return 8'h3D;
            4'd2:    return 8'h0F;
            4'd3:    return 8'h3F;
            4'd4:    return 8'h0E;
            4'd7:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    // implemented-bit masks, graphics file
    function automatic logic [7:0] gfx_keep(input logic [3:0] i);
        case (i)
            4'd3:    return 8'h1F;
            4'd4:    return 8'h03;
            4'd5:    return 8'h7B;
            4'd8:    return 8'hFF;
            default: return 8'h0F;
        endcase
    endfunction

endpackage

// File: rtl/vga_reg_bank.sv
module vga_reg_bank
    import vga_idx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter bit IS_GFX = 1'b0,
    parameter int LANES  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LANES-1:0]     idx_we,
    input  logic [LANES-1:0]     dat_we,
    input  logic [LANES*8-1:0]   lane_byte,
    output logic [DEPTH*8-1:0]   regs_flat,
    output logic [DEPTH*8-1:0]   regs_next_flat,
    output logic [LANES-1:0]     lane_miss
);

    localparam logic [7:0] LIMIT = 8'(DEPTH);

    logic [7:0] keep [DEPTH];
    logic [7:0] regs_q [DEPTH];
    logic [7:0] regs_n [DEPTH];
    logic [7:0] idx_q, idx_n;

    for (genvar g = 0; g < DEPTH; g++) begin : g_keep
        assign keep[g] = IS_GFX ? gfx_keep(4'(g)) : seq_keep(4'(g));
        assign regs_flat[g*8 +: 8]      = regs_q[g];
        assign regs_next_flat[g*8 +: 8] = regs_n[g];
    end

    // lanes are applied in order: a later lane sees an index set by an earlier one
    always_comb begin
        idx_n     = idx_q;
        lane_miss = '0;
        for (int e = 0; e < DEPTH; e++) regs_n[e] = regs_q[e];
        for (int l = 0; l < LANES; l++) begin
            if (idx_we[l]) begin
                idx_n = lane_byte[l*8 +: 8];
            end else if (dat_we[l]) begin
                if (idx_n >= LIMIT) lane_miss[l] = 1'b1;
                for (int e = 0; e < DEPTH; e++)
                    if (idx_n == 8'(e)) regs_n[e] = lane_byte[l*8 +: 8] & keep[e];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            for (int e = 0; e < DEPTH; e++) regs_q[e] <= '0;
        end else begin
            idx_q <= idx_n;
            for (int e = 0; e < DEPTH; e++) regs_q[e] <= regs_n[e];
        end
    end

endmodule

// File: rtl/vga_cache_fsm.sv
module vga_cache_fsm
    import vga_idx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_rise,
    input  logic      drop_req,
    output cache_st_t state
);

    cache_st_t state_q, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IDLE_UNINIT;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            IDLE_UNINIT: if (mode_rise) state_n = CACHE_ON;   // ARM
            CACHE_ON:    if (drop_req)  state_n = CACHE_OFF;  // DROP
            CACHE_OFF:   state_n = CACHE_OFF;
            default:     state_n = IDLE_UNINIT;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/vga_idx_port.sv
module vga_idx_port
    import vga_idx_pkg::*;
#(
    parameter int SEQ_DEPTH = 8,
    parameter int GFX_DEPTH = 9,
    parameter int MODE_REG  = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   io_wr,
    input  logic                   io_wide,
    input  logic [15:0]            io_port,
    input  logic [15:0]            io_data,
    input  logic                   cache_drop,
    output logic [SEQ_DEPTH*8-1:0] seq_regs,
    output logic [GFX_DEPTH*8-1:0] gfx_regs,
    output logic                   std_mode,
    output logic [1:0]             cache_state,
    output logic                   wr_unhandled
);

    localparam int LANES = 2;

    logic [LANES-1:0] lane_vld, seq_iw, seq_dw, gfx_iw, gfx_dw, other;
    logic [LANES-1:0] seq_miss, gfx_miss;
    logic [15:0]      lane_port [LANES];
    logic [SEQ_DEPTH*8-1:0] seq_next;
    logic [GFX_DEPTH*8-1:0] gfx_unused_next;
    logic std_q, std_n, unh_q;
    cache_st_t cst;

    assign lane_vld = {io_wr & io_wide, io_wr};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_port[l] = io_port + 16'(l);
        assign seq_iw[l] = lane_vld[l] && lane_port[l] == PORT_SEQ_IDX;
        assign seq_dw[l] = lane_vld[l] && lane_port[l] == PORT_SEQ_DAT;
        assign gfx_iw[l] = lane_vld[l] && lane_port[l] == PORT_GFX_IDX;
        assign gfx_dw[l] = lane_vld[l] && lane_port[l] == PORT_GFX_DAT;
        assign other[l]  = lane_vld[l] && !(seq_iw[l] || seq_dw[l] || gfx_iw[l] || gfx_dw[l]);
    end

    vga_reg_bank #(.DEPTH(SEQ_DEPTH), .IS_GFX(1'b0), .LANES(LANES)) u_seq (
        .clk(clk), .rst_n(rst_n), .idx_we(seq_iw), .dat_we(seq_dw),
        .lane_byte(io_data), .regs_flat(seq_regs), .regs_next_flat(seq_next),
        .lane_miss(seq_miss)
    );

    vga_reg_bank #(.DEPTH(GFX_DEPTH), .IS_GFX(1'b1), .LANES(LANES)) u_gfx (
        .clk(clk), .rst_n(rst_n), .idx_we(gfx_iw), .dat_we(gfx_dw),
        .lane_byte(io_data), .regs_flat(gfx_regs), .regs_next_flat(gfx_unused_next),
        .lane_miss(gfx_miss)
    );

    assign std_n = (seq_next[MODE_REG*8 +: 8] == 8'h00);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            std_q <= 1'b0;
            unh_q <= 1'b0;
        end else begin
            if (io_wr) std_q <= std_n;
            unh_q <= |(seq_miss | gfx_miss | other);
        end
    end

    vga_cache_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .mode_rise(io_wr & std_n & ~std_q),
        .drop_req(cache_drop),
        .state(cst)
    );

    assign std_mode     = std_q;
    assign cache_state  = cst;
    assign wr_unhandled = unh_q;

endmodule

// File: rtl/vga_idx_port_chk.sv
module vga_idx_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_wr,
    input logic [63:0] seq_regs,
    input logic [71:0] gfx_regs,
    input logic        std_mode,
    input logic [1:0]  cache_state,
    input logic        wr_unhandled
);

    // R10
    off_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_state == 2'd2 |=> cache_state == 2'd2);

    // R10
    on_no_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_state == 2'd1 |=> cache_state != 2'd0);

    // R9
    arm_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_state == 2'd1 && $past(cache_state) == 2'd0) |-> (std_mode && !$past(std_mode)));

    // R9
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_state != 2'd3);

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(std_mode));

    // R6
    unh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> !wr_unhandled);

    // R3
    seq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_regs[55:40] == 16'h0 && seq_regs[7:2] == 6'h0);

    // R4
    gfx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gfx_regs[47:40] & 8'h84) == 8'h0 && gfx_regs[39:34] == 6'h0);

endmodule

bind vga_idx_port vga_idx_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .seq_regs(seq_regs),
    .gfx_regs(gfx_regs), .std_mode(std_mode), .cache_state(cache_state),
    .wr_unhandled(wr_unhandled)
);

// File: tb/tb_vga_idx_port.sv
`timescale 1ns/1ps
module tb_vga_idx_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_wide = 1'b0, cache_drop = 1'b0;
    logic [15:0] io_port = '0, io_data = '0;
    logic [63:0] seq_regs;
    logic [71:0] gfx_regs;
    logic        std_mode, wr_unhandled;
    logic [1:0]  cache_state;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    vga_idx_port dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_wide(io_wide),
        .io_port(io_port), .io_data(io_data), .cache_drop(cache_drop),
        .seq_regs(seq_regs), .gfx_regs(gfx_regs), .std_mode(std_mode),
        .cache_state(cache_state), .wr_unhandled(wr_unhandled)
    );

    typedef struct packed {
        logic        wide;
        logic [15:0] port;
        logic [15:0] data;
        logic        gfx;
        logic [3:0]  idx;
        logic [7:0]  val;
        logic        unh;
        logic        stdm;
        logic [1:0]  cst;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 16'h03C4, 16'h0002, 1'b0, 4'd2, 8'h00, 1'b0, 1'b1, 2'd1},
        '{1'b0, 16'h03C5, 16'h00FF, 1'b0, 4'd2, 8'h0F, 1'b0, 1'b1, 2'd1},
        '{1'b0, 16'h03C4, 16'h0001, 1'b0, 4'd1, 8'h00, 1'b0, 1'b1, 2'd1},
        '{1'b0, 16'h03C5, 16'h00FF, 1'b0, 4'd1, 8'h3D, 1'b0, 1'b1, 2'd1},
        '{1'b0, 16'h03C4, 16'h0000, 1'b0, 4'd0, 8'h00, 1'b0, 1'b1, 2'd1},
        '{1'b0, 16'h03C5, 16'h00AB, 1'b0, 4'd0, 8'h03, 1'b0, 1'b1, 2'd1},
        '{1'b1, 16'h03C4, 16'hC403, 1'b0, 4'd3, 8'h04, 1'b0, 1'b1, 2'd1},
        '{1'b1, 16'h03C4, 16'hFF04, 1'b0, 4'd4, 8'h0E, 1'b0, 1'b1, 2'd1},
        '{1'b0, 16'h03C4, 16'h0005, 1'b0, 4'd5, 8'h00, 1'b0, 1'b1, 2'd1},
        '{1'b0, 16'h03C5, 16'h00FF, 1'b0, 4'd5, 8'h00, 1'b0, 1'b1, 2'd1},
        '{1'b0, 16'h03C4, 16'h0008, 1'b0, 4'd0, 8'h03, 1'b0, 1'b1, 2'd1},
        '{1'b0, 16'h03C5, 16'h0077, 1'b0, 4'd0, 8'h03, 1'b1, 1'b1, 2'd1},
        '{1'b1, 16'h03CE, 16'h5A05, 1'b1, 4'd5, 8'h5A, 1'b0, 1'b1, 2'd1},
        '{1'b1, 16'h03CE, 16'hFF03, 1'b1, 4'd3, 8'h1F, 1'b0, 1'b1, 2'd1},
        '{1'b1, 16'h03CE, 16'hFF08, 1'b1, 4'd8, 8'hFF, 1'b0, 1'b1, 2'd1},
        '{1'b1, 16'h03CE, 16'hFF04, 1'b1, 4'd4, 8'h03, 1'b0, 1'b1, 2'd1},
        '{1'b1, 16'h03CE, 16'hFF06, 1'b1, 4'd6, 8'h0F, 1'b0, 1'b1, 2'd1},
        '{1'b0, 16'h03CE, 16'h0009, 1'b1, 4'd4, 8'h03, 1'b0, 1'b1, 2'd1},
        '{1'b0, 16'h03CF, 16'h0012, 1'b1, 4'd8, 8'hFF, 1'b1, 1'b1, 2'd1},
        '{1'b0, 16'h03C0, 16'h0099, 1'b1, 4'd8, 8'hFF, 1'b1, 1'b1, 2'd1},
        '{1'b1, 16'h03C5, 16'h1122, 1'b0, 4'd0, 8'h03, 1'b1, 1'b1, 2'd1},
        '{1'b1, 16'h03C4, 16'hFF06, 1'b0, 4'd6, 8'h00, 1'b0, 1'b1, 2'd1},
        '{1'b1, 16'h03C4, 16'h0107, 1'b0, 4'd7, 8'h01, 1'b0, 1'b0, 2'd1},
        '{1'b0, 16'h03C5, 16'h0000, 1'b0, 4'd7, 8'h00, 1'b0, 1'b1, 2'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, registered results are sampled at the next falling edge
    task automatic port_wr(input logic wide, input logic [15:0] port, input logic [15:0] data);
        @(negedge clk);
        io_wr = 1'b1; io_wide = wide; io_port = port; io_data = data;
        @(negedge clk);
        io_wr = 1'b0; io_wide = 1'b0;
    endtask

    task automatic drop_pulse();
        @(negedge clk);
        cache_drop = 1'b1;
        @(negedge clk);
        cache_drop = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R11 reset state
        check("R11 seq", 32'(seq_regs == '0), 32'd1);
        check("R11 gfx", 32'(gfx_regs == '0), 32'd1);
        check("R11 std", 32'(std_mode), 32'd0);
        check("R11 cache", 32'(cache_state), 32'd0);
        check("R11 unh", 32'(wr_unhandled), 32'd0);

        // R10 drop ignored while uninitialized
        drop_pulse();
        check("R10 drop ignored", 32'(cache_state), 32'd0);

        // table: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            port_wr(TBL[i].wide, TBL[i].port, TBL[i].data);
            check($sformatf("R1/R2/R3/R4/R7 vec%0d reg", i),
                  32'(TBL[i].gfx ? gfx_regs[TBL[i].idx*8 +: 8] : seq_regs[TBL[i].idx*8 +: 8]),
                  32'(TBL[i].val));
            check($sformatf("R5/R6 vec%0d unhandled", i), 32'(wr_unhandled), 32'(TBL[i].unh));
            check($sformatf("R8 vec%0d std", i), 32'(std_mode), 32'(TBL[i].stdm));
            check($sformatf("R9 vec%0d cache", i), 32'(cache_state), 32'(TBL[i].cst));
        end

        // R6 flag drops when idle
        @(negedge clk);
        check("R6 idle unh", 32'(wr_unhandled), 32'd0);

        // R10 drop from enabled, then terminal
        drop_pulse();
        check("R10 drop", 32'(cache_state), 32'd2);
        port_wr(1'b1, 16'h03C4, 16'h0107);
        check("R8 std low", 32'(std_mode), 32'd0);
        port_wr(1'b0, 16'h03C5, 16'h0000);
        check("R8 std high", 32'(std_mode), 32'd1);
        check("R10 terminal", 32'(cache_state), 32'd2);

        // R9 arming only on a rise of the flag
        do_reset();
        port_wr(1'b1, 16'h03C4, 16'h0107);
        check("R9 no rise std", 32'(std_mode), 32'd0);
        check("R9 no rise cache", 32'(cache_state), 32'd0);
        drop_pulse();
        check("R10 drop ignored again", 32'(cache_state), 32'd0);
        port_wr(1'b0, 16'h03C5, 16'h0000);
        check("R9 arm", 32'(cache_state), 32'd1);
        check("R8 std after arm", 32'(std_mode), 32'd1);

        finish_run();
    end

endmodule